// File: doc/BRIEF.md
# ADC Result Output Port

This block hands an 18-bit conversion result to a host processor over one shared set of data pins. It captures each new result when the converter pulses a valid strobe. It then presents that result in one of four formats, chosen by a two-bit mode input: a full 18-bit parallel word, a 16-bit word read in two accesses, an 8-bit byte read in two accesses, or a serial stream shifted out by a host-supplied serial clock.

The host enables the pins with active-low chip select and read enable. When the pins are not enabled, every bit is released. An address input picks which part of the result an access returns. A coding input picks straight binary or two's complement, except in full-width mode.

Pin drivers are modelled as a data vector plus a per-bit output enable. The pad ring turns these into three-state pins. A released bit also drives 0 on its data line. The converter, the analogue side and the I/O levels are outside this block.

Top module: `adc_result_port`

## Requirements
- R1: Unless `cs_n` and `rd_n` are both low, `dbus_oe` is all zeros and `dbus` is all zeros. Any bit whose enable is low also drives 0.
- R2: With `mode_sel` = 00 and the pins enabled, all 18 enables are high and `dbus[17:0]` equals the stored result in straight binary, whatever `twos_sel` is.
- R3: With `mode_sel` = 01 and the pins enabled, `dbus_oe[15:0]` is high and `dbus_oe[17:16]` is low. With `addr_sel` = 0, `dbus[15:0]` carries result bits 17..2. With `addr_sel` = 1, `dbus[15:0]` carries bits 1..0 in its two low bits and zeros above them.
- R4: With `mode_sel` = 10 and the pins enabled, only `dbus[7:0]` is enabled. It carries result bits 17..10 when `addr_sel` = 0 and bits 9..2 when `addr_sel` = 1.
- R5: When `twos_sel` = 1 in modes 01, 10 and 11, the result's bit 17 is inverted before it is mapped onto the pins. This gives two's complement from a straight-binary result.
- R6: The stored result changes only in a cycle where `res_valid` is high. Between strobes, reads return the previous result even if `res_data` changes.
- R7: With `mode_sel` = 11, a `res_valid` strobe loads the coded result into the serial shifter and `sdo` shows bit 17. Each later rising edge of `sclk` advances `sdo` by one bit, MSB first, within three system clocks. When the pins are enabled, `dbus[0]` carries `sdo`, only `dbus_oe[0]` is high, and all other bits are released.
- R8: After 18 serial clock rising edges since the last load, `sdo` stays 0 for any further edges.
- R9: After reset, the stored result and the serial shifter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_data | input | 18 | New conversion result, straight binary |
| res_valid | input | 1 | One-cycle strobe that captures `res_data` |
| mode_sel | input | 2 | 00 full word, 01 16-bit, 10 8-bit, 11 serial |
| addr_sel | input | 1 | Selects the first (0) or second (1) part of the result |
| twos_sel | input | 1 | 1 = two's complement coding (not in mode 00) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk | input | 1 | Serial shift clock from the host, sampled by `clk` |
| dbus | output | 18 | Data pin values |
| dbus_oe | output | 18 | Per-bit output enable for `dbus` |
| sdo | output | 1 | Serial data bit, also muxed onto `dbus[0]` |

## Verification
A strobe on `res_valid` reaches the stored result and the serial shifter at the next rising edge, so a read placed after that edge sees the new value.

The parallel paths from mode, address, coding, chip select and read enable to the pins are combinational. The bench drives these inputs on a falling edge and samples 1 ns later.

A rising edge on `sclk` passes through two synchronizer flops and one edge-detect stage. `sdo` therefore moves at the third system clock after the edge. The bench holds `sclk` high and then low for four system clocks each, and samples only after the low phase.

// File: rtl/adc_port_pkg.sv
// Package: shared mode encoding for the ADC result output port.
// Assumes: the mode pins map directly onto this two-bit enum.
package adc_port_pkg;

    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_WORD = 2'b01,
        MODE_BYTE = 2'b10,
        MODE_SER  = 2'b11
    } port_mode_e;

endpackage

// File: rtl/adc_coder.sv
// Module: adc_coder
// Converts a straight-binary result to two's complement by inverting the MSB.
// Assumes: the incoming value is offset binary with midscale at MSB set.
module adc_coder #(
    parameter int W = 18
) (
    input  logic [W-1:0] raw,
    input  logic         flip_en,
    output logic [W-1:0] coded
);

    // Invert the top bit only when the flip is requested.
    always_comb begin
        coded        = raw;
        coded[W-1]   = raw[W-1] ^ flip_en;
    end

endmodule

// File: rtl/adc_par_mux.sv
// Module: adc_par_mux
// Maps the coded result onto the shared pins for the selected mode and
// produces per-bit output enables; a disabled port releases every pin.
// Assumes: RES_W > WORD_W >= 2*BYTE_W and RES_W - WORD_W <= WORD_W.
module adc_par_mux
    import adc_port_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0] word,
    input  port_mode_e       mode,
    input  logic             addr_sel,
    input  logic             enable,
    input  logic             ser_bit,
    output logic [RES_W-1:0] bus,
    output logic [RES_W-1:0] oe
);

    localparam int TAIL_W = RES_W - WORD_W;

    logic [WORD_W-1:0] upper_word;
    logic [WORD_W-1:0] tail_word;
    logic [BYTE_W-1:0] sel_byte;

    // Carve the upper word, the zero-padded tail and the selected byte.
    always_comb begin
        upper_word = word[RES_W-1 -: WORD_W];
        tail_word  = '0;
        tail_word[TAIL_W-1:0] = word[TAIL_W-1:0];
        sel_byte   = addr_sel ? upper_word[BYTE_W-1:0]
                              : upper_word[WORD_W-1 -: BYTE_W];
    end

    // Drive pins and enables for the active mode, all released when idle.
    always_comb begin
        bus = '0;
        oe  = '0;
        if (enable) begin
            unique case (mode)
                MODE_FULL: begin
                    bus = word;
                    oe  = '1;
                end
                MODE_WORD: begin
                    bus[WORD_W-1:0] = addr_sel ? tail_word : upper_word;
                    oe[WORD_W-1:0]  = '1;
                end
                MODE_BYTE: begin
                    bus[BYTE_W-1:0] = sel_byte;
                    oe[BYTE_W-1:0]  = '1;
                end
                MODE_SER: begin
                    bus[0] = ser_bit;
                    oe[0]  = 1'b1;
                end
                default: begin
                    bus = '0;
                    oe  = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_ser_shift.sv
// Module: adc_ser_shift
// Serial shifter: loads the coded result on a strobe and moves one bit per
// synchronized rising edge of the host serial clock, MSB first, zero fill.
// Assumes: sclk high and low phases each last at least SYNC_STAGES+1 clocks.
module adc_ser_shift #(
    parameter int RES_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] load_word,
    input  logic             sclk,
    output logic             sdo
);

    localparam int CNT_W = $clog2(RES_W + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [RES_W-1:0]       shreg_q;

    // Bring the serial clock into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sclk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Load on strobe, otherwise shift left with zero fill on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= load_word;
        end else if (rise) begin
            shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
        end
    end

    assign sdo = shreg_q[RES_W-1];

    // Checker state: count edges since the last load, saturating.
    logic [CNT_W-1:0] edge_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q <= CNT_W'(RES_W);
        end else if (load) begin
            edge_cnt_q <= '0;
        end else if (rise && edge_cnt_q < CNT_W'(RES_W)) begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    assert_load_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sdo == $past(load_word[RES_W-1]));

    assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_cnt_q == CNT_W'(RES_W)) |-> !sdo);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> !sdo);

endmodule

// File: rtl/adc_result_port.sv
// Module: adc_result_port
// Holds the latest conversion result and presents it to a host in full,
// 16-bit, 8-bit or serial form on one shared set of pins.
// Assumes: res_valid is a single-cycle strobe in the clk domain.
module adc_result_port
    import adc_port_pkg::*;
#(
    parameter int RES_W       = 18,
    parameter int WORD_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_valid,
    input  logic [1:0]       mode_sel,
    input  logic             addr_sel,
    input  logic             twos_sel,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             sclk,
    output logic [RES_W-1:0] dbus,
    output logic [RES_W-1:0] dbus_oe,
    output logic             sdo
);

    port_mode_e       mode;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] par_word;
    logic [RES_W-1:0] ser_word;
    logic             par_flip;
    logic             port_en;

    assign mode     = port_mode_e'(mode_sel);
    assign port_en  = ~cs_n & ~rd_n;
    assign par_flip = twos_sel & (mode != MODE_FULL);

    // Capture the result only on the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (res_valid) begin
            res_q <= res_data;
        end
    end

    adc_coder #(.W(RES_W)) par_coder_i (
        .raw     (res_q),
        .flip_en (par_flip),
        .coded   (par_word)
    );

    adc_coder #(.W(RES_W)) ser_coder_i (
        .raw     (res_data),
        .flip_en (twos_sel),
        .coded   (ser_word)
    );

    adc_ser_shift #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (res_valid),
        .load_word (ser_word),
        .sclk      (sclk),
        .sdo       (sdo)
    );

    adc_par_mux #(.RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) mux_i (
        .word     (par_word),
        .mode     (mode),
        .addr_sel (addr_sel),
        .enable   (port_en),
        .ser_bit  (sdo),
        .bus      (dbus),
        .oe       (dbus_oe)
    );

    assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dbus_oe == '0 && dbus == '0));

    assert_full_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && mode == MODE_FULL) |-> (dbus_oe == '1 && dbus == res_q));

    assert_word_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && mode == MODE_WORD) |-> $countones(dbus_oe) == WORD_W);

    assert_byte_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && mode == MODE_BYTE) |-> $countones(dbus_oe) == BYTE_W);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(res_q));

    assert_ser_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && mode == MODE_SER) |-> (dbus_oe == RES_W'(1) && dbus[0] == sdo));

endmodule

// File: tb/adc_result_port_tb_top.sv
`timescale 1ns/1ps
module adc_result_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] res_data;
    logic        res_valid;
    logic [1:0]  mode_sel;
    logic        addr_sel;
    logic        twos_sel;
    logic        cs_n;
    logic        rd_n;
    logic        sclk;
    logic [17:0] dbus;
    logic [17:0] dbus_oe;
    logic        sdo;

    int n_cmp = 0;
    int n_bad = 0;
    logic [17:0] ref_res;

    always #2.5 clk = ~clk;

    adc_result_port dut_i (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .mode_sel(mode_sel), .addr_sel(addr_sel), .twos_sel(twos_sel),
        .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk),
        .dbus(dbus), .dbus_oe(dbus_oe), .sdo(sdo)
    );

    function automatic logic [35:0] exp_par(logic [1:0] m, logic a, logic t,
                                            logic c, logic r, logic [17:0] v);
        logic [17:0] w;
        logic [17:0] oe;
        logic [17:0] d;
        oe = '0;
        d  = '0;
        w  = (t && m != 2'b00) ? (v ^ 18'h20000) : v;
        if (!c && !r) begin
            case (m)
                2'b00: begin oe = '1; d = w; end
                2'b01: begin
                    oe = 18'h0FFFF;
                    d  = a ? {16'b0, w[1:0]} : {2'b0, w[17:2]};
                end
                default: begin
                    oe = 18'h000FF;
                    d  = a ? {10'b0, w[9:2]} : {10'b0, w[17:10]};
                end
            endcase
        end
        return {oe, d};
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(logic [17:0] v);
        @(negedge clk);
        res_data  = v;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        ref_res   = v;
    endtask

    task automatic read_chk(logic [1:0] m, logic a, logic t, logic c, logic r);
        string tag;
        @(negedge clk);
        mode_sel = m; addr_sel = a; twos_sel = t; cs_n = c; rd_n = r;
        #1;
        if (c || r)          tag = "R1";
        else if (m == 2'b00) tag = "R2";
        else if (m == 2'b01) tag = t ? "R3/R5" : "R3";
        else                 tag = t ? "R4/R5" : "R4";
        check(tag, {dbus_oe, dbus}, exp_par(m, a, t, c, r, ref_res));
    endtask

    task automatic read_all();
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < 2; a++)
                for (int t = 0; t < 2; t++)
                    read_chk(2'(m), 1'(a), 1'(t), 1'b0, 1'b0);
    endtask

    task automatic ser_run(logic [17:0] v, logic t);
        logic [17:0] w;
        logic        b;
        @(negedge clk);
        mode_sel = 2'b11; twos_sel = t; cs_n = 1'b0; rd_n = 1'b0;
        pulse(v);
        w = t ? (v ^ 18'h20000) : v;
        for (int i = 0; i < 21; i++) begin
            #1;
            b = (i < 18) ? w[17 - i] : 1'b0;
            // R7 bit order and pin mux, R8 zero fill after 18 edges
            check((i < 18) ? "R7" : "R8", {dbus_oe, dbus, 1'b0, sdo},
                  {18'h00001, 17'b0, b, 1'b0, b});
            @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [17:0] v;
        void'($urandom(32'd4711));
        rst_n = 1'b0; res_data = '0; res_valid = 1'b0; mode_sel = 2'b00;
        addr_sel = 1'b0; twos_sel = 1'b0; cs_n = 1'b1; rd_n = 1'b1; sclk = 1'b0;
        ref_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state seen through a full-width read and the serial pin
        read_chk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9", {35'b0, sdo}, 36'b0);

        // R2..R5 directed corner values
        pulse(18'h3FFFF); read_all();
        pulse(18'h00000); read_all();
        pulse(18'h20000); read_all();
        pulse(18'h1FFFF); read_all();
        pulse(18'h2A5C3); read_all();

        // R1: any disabled combination releases all pins
        read_chk(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        read_chk(2'b01, 1'b1, 1'b1, 1'b0, 1'b1);
        read_chk(2'b10, 1'b0, 1'b1, 1'b1, 1'b1);

        // R6: new input data without a strobe leaves the stored result
        @(negedge clk);
        res_data = 18'h15555;
        repeat (3) @(negedge clk);
        read_all();

        // Random mix of results, modes, addresses, coding and enables
        for (int k = 0; k < 200; k++) begin
            v = 18'($urandom);
            if ($urandom_range(0, 3) != 0) pulse(v);
            else begin
                @(negedge clk);
                res_data = v;   // R6: no strobe, reference unchanged
            end
            for (int j = 0; j < 4; j++)
                read_chk(2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom),
                         1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
        end

        // R7, R8, R5: serial stream in both codings
        ser_run(18'h2B3C5, 1'b0);
        ser_run(18'h0F0F1, 1'b1);
        ser_run(18'($urandom), 1'b1);

        // R7: serial mode with the port disabled releases dbus
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        check("R7", {dbus_oe, dbus}, 36'b0);

        summary();
        $finish;
    end

endmodule